// File: doc/BRIEF.md
# Bus Turnaround Idle Cycle Inserter

This block belongs to an external memory bus controller. It decides how many idle cycles must separate one external access from the next. The aim is to give a slow device's read data buffer time to release the shared data lines before another access drives them. It keeps the area number and the direction of the most recent access. When a new request arrives, it decides whether the area or the direction has changed in a way that could cause a collision. It then reads a per-area 2-bit idle setting and withholds the start grant until enough empty bus cycles have passed.

Bus cycles that were already empty before the request count toward the idle requirement. A bus arbitration handover between two accesses leaves enough empty time on its own, so it cancels the requirement. The requester holds its request, area and direction stable until it sees the grant. The grant is combinational from the request and the registered history, so an access can start in the same cycle its request appears when no idle time is owed.

Top module: `turngap_top`

## Requirements
- R1: When the new access targets a different area from the previous access, the grant is held off by the idle count configured for the previous access's area, less the empty cycles already seen.
- R2: A write request following a read of the same area is held off by that area's configured idle count, less the empty cycles already seen.
- R3: A write following a write to the same area is granted with no inserted idle cycles.
- R4: A read following either a read or a write to the same area is granted with no inserted idle cycles.
- R5: Area n's idle count is the unsigned value of `idle_cfg[2n+1:2n]`, where 0 to 3 means 0 to 3 cycles. The field at bits [3:2], which belongs to area 1, is ignored, and the count after an area-1 access is always zero.
- R6: A cycle in which no access is started and `acc_active` is low counts as empty. Inserted idle cycles equal the configured count minus the empty cycles since the last access, with a floor of zero.
- R7: If `arb_event` pulsed at any point since the last grant, or pulses in the request cycle itself, the request is granted with no inserted idle cycles.
- R8: After reset, `start_grant` and `holdoff_busy` are low with no request present, and the first access is granted with no inserted idle cycles.
- R9: `start_grant` is never high while `acc_active` is high or `req_valid` is low. `holdoff_busy` is high exactly when a request is present and not granted.
- R10: A cycle with `acc_active` high is not empty. It resets the empty count, so an access that ends just before a request gives up no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until granted |
| req_area | input | 3 | Area number of the requested access |
| req_write | input | 1 | 1 = write driven by this controller, 0 = read |
| acc_active | input | 1 | An external access is still occupying the bus |
| arb_event | input | 1 | Pulse: bus arbitration handover took place |
| idle_cfg | input | 14 | Per-area 2-bit idle counts, area n at bits [2n+1:2n] |
| start_grant | output | 1 | Access may start in this cycle |
| holdoff_busy | output | 1 | Request present but held off |

## Verification
The bench works through every direction pairing on a single area. A design that treated write-to-write or read-after-write as a turnaround would lose cycles, and one that missed read-to-write would let read data and write data collide. It changes areas with each distinct idle field so that a field taken from the wrong bit slice, from the new area instead of the previous one, or honoured for area 1, shows up as a wrong wait length. Pre-request gaps shorter than, equal to and longer than the setting test the subtraction and its zero floor. Other cases hold the request while an access is still active, and pulse arbitration during a gap, catching a counter that keeps counting through busy cycles and a design that ignores the handover.

// File: rtl/turngap_pkg.sv
package turngap_pkg;
  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;
  localparam int DEF_AREAS    = 7;
  localparam int DEF_IDLE_W   = 2;
  localparam int NO_IDLE_AREA = 1;
endpackage

// File: rtl/turngap_history.sv
module turngap_history
  import turngap_pkg::*;
#(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [AREA_W-1:0] take_area,
  input  dir_e              take_dir,
  input  logic              arb_pulse,
  output logic              hist_valid,
  output logic [AREA_W-1:0] hist_area,
  output dir_e              hist_dir,
  output logic              arb_seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_valid <= 1'b0;
      hist_area  <= '0;
      hist_dir   <= DIR_WRITE;
      arb_seen   <= 1'b0;
    end else begin
      if (take) begin
        hist_valid <= 1'b1;
        hist_area  <= take_area;
        hist_dir   <= take_dir;
        arb_seen   <= 1'b0;
      end else if (arb_pulse) begin
        arb_seen   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/turngap_empty_ctr.sv
module turngap_empty_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_used,
  output logic [CNT_W-1:0] empty_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_cnt <= '0;
    end else if (bus_used) begin
      empty_cnt <= '0;
    end else if (empty_cnt != CNT_MAX) begin
      empty_cnt <= empty_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/turngap_need.sv
module turngap_need
  import turngap_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int IDLE_W    = 2,
  parameter int AREA_W    = 3
) (
  input  logic                        hist_valid,
  input  logic [AREA_W-1:0]           hist_area,
  input  dir_e                        hist_dir,
  input  logic                        arb_any,
  input  logic [AREA_W-1:0]           req_area,
  input  dir_e                        req_dir,
  input  logic [NUM_AREAS*IDLE_W-1:0] idle_cfg,
  output logic [IDLE_W-1:0]           need
);
  logic [IDLE_W-1:0] field_arr [NUM_AREAS];
  logic [IDLE_W-1:0] sel_field;
  logic              turnaround;

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_field
    if (a == NO_IDLE_AREA) begin : g_none
      logic [IDLE_W-1:0] unused_field;
      assign unused_field = idle_cfg[a*IDLE_W +: IDLE_W];
      assign field_arr[a] = '0;
    end else begin : g_cfg
      assign field_arr[a] = idle_cfg[a*IDLE_W +: IDLE_W];
    end
  end

  always_comb begin
    sel_field = '0;
    if (int'(hist_area) < NUM_AREAS) begin
      sel_field = field_arr[hist_area];
    end
  end

  assign turnaround = (hist_area != req_area) ||
                      (hist_dir == DIR_READ && req_dir == DIR_WRITE);

  assign need = (hist_valid && !arb_any && turnaround) ? sel_field : '0;
endmodule

// File: rtl/turngap_top.sv
module turngap_top
  import turngap_pkg::*;
#(
  parameter  int NUM_AREAS = DEF_AREAS,
  parameter  int IDLE_W    = DEF_IDLE_W,
  localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int CFG_W     = NUM_AREAS * IDLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              acc_active,
  input  logic              arb_event,
  input  logic [CFG_W-1:0]  idle_cfg,
  output logic              start_grant,
  output logic              holdoff_busy
);
  dir_e              req_dir;
  logic              hist_valid;
  logic [AREA_W-1:0] hist_area;
  dir_e              hist_dir;
  logic              arb_seen;
  logic [IDLE_W-1:0] need;
  logic [IDLE_W-1:0] empty_cnt;
  logic              gap_met;

  assign req_dir = req_write ? DIR_WRITE : DIR_READ;

  turngap_history #(.AREA_W(AREA_W)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .take       (start_grant),
    .take_area  (req_area),
    .take_dir   (req_dir),
    .arb_pulse  (arb_event),
    .hist_valid (hist_valid),
    .hist_area  (hist_area),
    .hist_dir   (hist_dir),
    .arb_seen   (arb_seen)
  );

  turngap_need #(
    .NUM_AREAS (NUM_AREAS),
    .IDLE_W    (IDLE_W),
    .AREA_W    (AREA_W)
  ) u_need (
    .hist_valid (hist_valid),
    .hist_area  (hist_area),
    .hist_dir   (hist_dir),
    .arb_any    (arb_seen | arb_event),
    .req_area   (req_area),
    .req_dir    (req_dir),
    .idle_cfg   (idle_cfg),
    .need       (need)
  );

  turngap_empty_ctr #(.CNT_W(IDLE_W)) u_empty (
    .clk       (clk),
    .rst       (rst),
    .bus_used  (start_grant | acc_active),
    .empty_cnt (empty_cnt)
  );

  assign gap_met      = (empty_cnt >= need);
  assign start_grant  = req_valid && !acc_active && gap_met;
  assign holdoff_busy = req_valid && !start_grant;
endmodule

// File: rtl/turngap_check.sv
module turngap_check #(
  parameter  int NUM_AREAS = 7,
  parameter  int IDLE_W    = 2,
  localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int MAX_IDLE  = (1 << IDLE_W) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [AREA_W-1:0] req_area,
  input logic              req_write,
  input logic              acc_active,
  input logic              arb_event,
  input logic              start_grant,
  input logic              holdoff_busy
);
  logic              seen;
  logic [AREA_W-1:0] last_area;
  logic              last_read;
  logic              arb_flag;
  int                wait_cnt;
  logic              ready_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      last_area <= '0;
      last_read <= 1'b0;
      arb_flag  <= 1'b0;
      wait_cnt  <= 0;
    end else begin
      if (start_grant) begin
        seen      <= 1'b1;
        last_area <= req_area;
        last_read <= !req_write;
        arb_flag  <= 1'b0;
      end else if (arb_event) begin
        arb_flag  <= 1'b1;
      end
      if (start_grant || acc_active || !req_valid) wait_cnt <= 0;
      else if (holdoff_busy)                       wait_cnt <= wait_cnt + 1;
    end
  end

  assign ready_now = req_valid && !acc_active;

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    start_grant |-> req_valid);                                           // R9
  AST_NO_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    acc_active |-> !start_grant);                                         // R9
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(start_grant && holdoff_busy));                                      // R9
  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (rst)
    (ready_now && !seen) |-> start_grant);                                // R8
  AST_WRITE_STREAM: assert property (@(posedge clk) disable iff (rst)
    (ready_now && seen && req_write && !last_read && req_area == last_area) |-> start_grant); // R3
  AST_SAME_AREA_READ: assert property (@(posedge clk) disable iff (rst)
    (ready_now && seen && !req_write && req_area == last_area) |-> start_grant); // R4
  AST_AREA1_FREE: assert property (@(posedge clk) disable iff (rst)
    (ready_now && seen && int'(last_area) == 1) |-> start_grant);         // R5
  AST_ARB_FREE: assert property (@(posedge clk) disable iff (rst)
    (ready_now && (arb_flag || arb_event)) |-> start_grant);              // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (holdoff_busy && !acc_active) |-> (wait_cnt < MAX_IDLE));             // R1
endmodule

bind turngap_top turngap_check #(.NUM_AREAS(NUM_AREAS), .IDLE_W(IDLE_W)) u_check (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_area     (req_area),
  .req_write    (req_write),
  .acc_active   (acc_active),
  .arb_event    (arb_event),
  .start_grant  (start_grant),
  .holdoff_busy (holdoff_busy)
);

// File: tb/turngap_top_test.sv
module turngap_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_area;
  logic        req_write;
  logic        acc_active;
  logic        arb_event;
  logic [13:0] idle_cfg;
  logic        start_grant;
  logic        holdoff_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // per-area field values; area 1 field is nonzero on purpose (must be ignored)
  int cfg_val [7] = '{2, 3, 3, 1, 2, 0, 3};

  // bench model of the previous access
  bit m_valid;
  int m_area;
  bit m_read;

  always #(CLK_PERIOD/2) clk = ~clk;

  turngap_top uut (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_area     (req_area),
    .req_write    (req_write),
    .acc_active   (acc_active),
    .arb_event    (arb_event),
    .idle_cfg     (idle_cfg),
    .start_grant  (start_grant),
    .holdoff_busy (holdoff_busy)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_wait(input int area, input bit wr, input int gap,
                                    input bit arb);
    int need;
    need = 0;
    if (m_valid && !arb && (area != m_area || (m_read && wr)) && m_area != 1)
      need = cfg_val[m_area];
    return (need > gap) ? need - gap : 0;
  endfunction

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; req_area = '0; req_write = 1'b0;
    acc_active = 1'b0; arb_event = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_valid = 1'b0;
  endtask

  // gap: empty cycles before the request; pre_act: cycles the request waits
  // behind an active access; post_act: active cycles after the grant
  task automatic run_access(input int area, input bit wr, input int gap,
                            input bit arb, input int pre_act, input int post_act,
                            input string tag);
    int exp_wait;
    int waits;
    int busy_bad;
    for (int i = 0; i < gap; i++) begin
      arb_event = arb && (i == 0);
      @(negedge clk);
    end
    arb_event = 1'b0;
    exp_wait = model_wait(area, wr, (pre_act > 0) ? 0 : gap, arb);
    req_valid = 1'b1; req_area = 3'(area); req_write = wr;
    busy_bad = 0;
    for (int i = 0; i < pre_act; i++) begin
      acc_active = 1'b1;
      #1;
      check(!start_grant && holdoff_busy, "R9", "grant/busy while access active",
            {start_grant, holdoff_busy}, 1);
      @(negedge clk);
    end
    acc_active = 1'b0;
    waits = 0;
    #1;
    while (!start_grant && waits < 8) begin
      if (!holdoff_busy) busy_bad++;
      waits++;
      @(negedge clk);
      #1;
    end
    check(busy_bad == 0, "R9", "busy low during hold-off", busy_bad, 0);
    check(!holdoff_busy, "R9", "busy at grant", holdoff_busy, 0);
    check(waits == exp_wait, tag, "idle cycles before grant", waits, exp_wait);
    m_valid = 1'b1; m_area = area; m_read = !wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < post_act; i++) begin
      acc_active = 1'b1;
      @(negedge clk);
    end
    acc_active = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < 7; a++) idle_cfg[a*2 +: 2] = 2'(cfg_val[a]);
    do_reset();
    #1;
    check(!start_grant && !holdoff_busy, "R8", "outputs after reset",
          {start_grant, holdoff_busy}, 0);
    @(negedge clk);
    run_access(2, 1'b0, 0, 1'b0, 0, 0, "R8");   // first access free
    run_access(2, 1'b0, 0, 1'b0, 0, 0, "R4");   // read after read
    run_access(2, 1'b1, 0, 1'b0, 0, 0, "R2");   // write after read: 3
    run_access(2, 1'b1, 0, 1'b0, 0, 0, "R3");   // write after write
    run_access(2, 1'b0, 0, 1'b0, 0, 0, "R4");   // read after write
    run_access(0, 1'b0, 0, 1'b0, 0, 0, "R1");   // from area 2: 3
    run_access(3, 1'b0, 0, 1'b0, 0, 0, "R5");   // from area 0: 2
    run_access(4, 1'b1, 0, 1'b0, 0, 0, "R5");   // from area 3: 1
    run_access(1, 1'b0, 1, 1'b0, 0, 0, "R6");   // from area 4: 2-1
    run_access(5, 1'b0, 0, 1'b0, 0, 0, "R5");   // from area 1: ignored
    run_access(6, 1'b0, 0, 1'b0, 0, 0, "R5");   // from area 5: 0
    run_access(0, 1'b0, 2, 1'b0, 0, 0, "R6");   // from area 6: 3-2
    run_access(2, 1'b0, 5, 1'b0, 0, 0, "R6");   // floor at zero
    run_access(4, 1'b1, 1, 1'b1, 0, 0, "R7");   // arbitration cancels 3
    run_access(6, 1'b1, 0, 1'b0, 0, 2, "R1");   // from area 4: 2
    run_access(0, 1'b0, 0, 1'b0, 0, 0, "R10");  // after active cycles: 3
    run_access(3, 1'b0, 3, 1'b0, 2, 0, "R10");  // active wipes gap: 2
    do_reset();
    run_access(5, 1'b1, 0, 1'b0, 0, 0, "R8");   // free again after reset
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule